// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

This block is a word-addressed register bank that controls a small group of general-purpose pins. Each pin has four 32-bit registers. Software uses them to set pad attributes and output enable, to drive and sample the pin, to choose how the pin raises interrupts, and to read and clear a latched event flag. Pull, function-select and drive-strength fields are exported on output ports for the pad ring. They have no electrical effect inside the block.

Every pin input passes through a two-flop synchronizer. After that, the pin is watched for a level or an edge of programmable polarity. Two independent enables gate each detected event. The first decides whether the event is recorded in the pin's status bit. The second decides whether the event contributes to the single combined interrupt output. With the capture enable off, an event can raise the interrupt while the status register stays at 0.

Top module: `gpio_irq_bank`

## Requirements
- R1: Pin p owns four registers at byte address 0x10*p. Pad configuration is at +0x0, input/output at +0x4, interrupt configuration at +0x8 and status at +0xC. Address bits 1:0 are ignored. A read returns its word on `rdata` at the clock edge that samples `rd_en`, and `rdata` holds that word until the next read.
- R2: In the pad configuration register, bits 1:0 are pull, bits 5:2 are function select, bits 8:6 are drive strength and bit 9 is output enable. The fields read back as written and appear on `pad_pull`, `pad_func`, `pad_drv` and `pin_oe` at the slice of that pin.
- R3: In the input/output register, bit 0 reads the pin input after two synchronizer flops. Bit 1 is writable, reads back, and drives `pin_out`.
- R4: In the interrupt configuration register, bit 0 is interrupt enable and bit 1 selects high/rising when 1 and low/falling when 0. Bit 2 selects edge detection when 1 and level detection when 0. Bit 3 is the status capture enable.
- R5: Status bit 0 is set by a detected event only when the capture enable (bit 3) is 1.
- R6: `irq` is the OR over all pins of interrupt enable AND pending. An event raises `irq` when bit 0 is set, whatever bit 3 holds. With no pin enabled, `irq` is 0.
- R7: In edge mode, pending is set by an active edge (rising for polarity 1, falling for polarity 0). The opposite edge does not set it. Pending stays set until a 1 is written to status bit 0.
- R8: In level mode, pending follows the active level of the synchronized input, with no latching.
- R9: Writing 1 to status bit 0 clears the status bit. Writing 0 leaves it unchanged.
- R10: When a detected event and a clearing write meet in the same cycle, the status stays set.
- R11: Unused register bits read as 0. Addresses whose pin index is NUM_PINS or more read as 0.
- R12: Synchronous reset clears every register. After reset, `irq`, `pin_oe` and `pin_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| pin_out | output | NUM_PINS | Driven output values |
| pin_oe | output | NUM_PINS | Output enables |
| pad_pull | output | 2*NUM_PINS | Pull field per pin |
| pad_func | output | 4*NUM_PINS | Function select per pin |
| pad_drv | output | 3*NUM_PINS | Drive strength per pin |
| irq | output | 1 | Combined interrupt |

## Verification
The detector is exercised with rising and falling pin transitions under each of the four mode and polarity combinations. These runs separate a correct edge from the ignored opposite edge, and a latched pending from a level that follows the pin. The two enables are switched one at a time to show that capture and interrupt are gated separately. Clearing writes are issued with a zero write-data bit, while the active level persists, and after the level is gone. This separates a working clear from one that is ignored or that beats a new event. Reads of a second pin and of out-of-range pin indices check that the address decode and the zero-fill are correct.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        REG_PAD  = 2'd0,
        REG_IO   = 2'd1,
        REG_ICFG = 2'd2,
        REG_STAT = 2'd3
    } reg_sel_e;

    // bit layout matches the register: pull at the bottom, oe at bit 9
    typedef struct packed {
        logic       oe;
        logic [2:0] drv;
        logic [3:0] func;
        logic [1:0] pull;
    } pad_cfg_t;

    // bit3 capture, bit2 edge, bit1 polarity, bit0 irq enable
    typedef struct packed {
        logic capture_en;
        logic edge_mode;
        logic pol_hi;
        logic irq_en;
    } irq_cfg_t;

    localparam int PAD_W  = $bits(pad_cfg_t);
    localparam int ICFG_W = $bits(irq_cfg_t);

    function automatic logic detect_event(irq_cfg_t c, logic cur, logic prev);
        logic act_now;
        logic act_prev;
        act_now  = c.pol_hi ? cur  : ~cur;
        act_prev = c.pol_hi ? prev : ~prev;
        return c.edge_mode ? (act_now & ~act_prev) : act_now;
    endfunction

    function automatic logic [WORD_W-1:0] read_word(reg_sel_e sel, pad_cfg_t pad,
                                                     logic out_val, logic in_lvl,
                                                     irq_cfg_t icfg, logic status);
        logic [WORD_W-1:0] w;
        w = '0;
        case (sel)
            REG_PAD:  w[PAD_W-1:0]  = pad;
            REG_IO:   w[1:0]        = {out_val, in_lvl};
            REG_ICFG: w[ICFG_W-1:0] = icfg;
            REG_STAT: w[0]          = status;
            default:  w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
    import gpio_bank_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_async,
    input  logic              wr_pad,
    input  logic              wr_io,
    input  logic              wr_icfg,
    input  logic              wr_stat,
    input  logic [WORD_W-1:0] wdata,
    output pad_cfg_t          pad_cfg,
    output logic              out_val,
    output irq_cfg_t          irq_cfg,
    output logic              status,
    output logic              in_lvl,
    output logic              irq_req
);
    logic prev_lvl;
    logic evt;
    logic clr;
    logic edge_pend;

    gpio_sync2 #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_async),
        .q   (in_lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pad_cfg  <= '0;
            out_val  <= 1'b0;
            irq_cfg  <= '0;
            prev_lvl <= 1'b0;
        end else begin
            prev_lvl <= in_lvl;
            if (wr_pad)  pad_cfg <= pad_cfg_t'(wdata[PAD_W-1:0]);
            if (wr_io)   out_val <= wdata[1];
            if (wr_icfg) irq_cfg <= irq_cfg_t'(wdata[ICFG_W-1:0]);
        end
    end

    always_comb begin
        evt = detect_event(irq_cfg, in_lvl, prev_lvl);
        clr = wr_stat & wdata[0];
    end

    // a new event outranks a clearing write in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            status    <= 1'b0;
            edge_pend <= 1'b0;
        end else begin
            if (irq_cfg.capture_en && evt) status <= 1'b1;
            else if (clr)                  status <= 1'b0;
            if (irq_cfg.edge_mode && evt)  edge_pend <= 1'b1;
            else if (clr)                  edge_pend <= 1'b0;
        end
    end

    assign irq_req = irq_cfg.irq_en & (irq_cfg.edge_mode ? edge_pend : evt);
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS    = 4,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [31:0]           wdata,
    output logic [31:0]           rdata,
    input  logic [NUM_PINS-1:0]   pin_in,
    output logic [NUM_PINS-1:0]   pin_out,
    output logic [NUM_PINS-1:0]   pin_oe,
    output logic [2*NUM_PINS-1:0] pad_pull,
    output logic [4*NUM_PINS-1:0] pad_func,
    output logic [3*NUM_PINS-1:0] pad_drv,
    output logic                  irq
);
    localparam int IDX_W = ADDR_W - 4;

    reg_sel_e            sel;
    logic [IDX_W-1:0]    pin_idx;
    logic [NUM_PINS-1:0] hit;
    logic [NUM_PINS-1:0] ien_vec;
    logic [NUM_PINS-1:0] cap_vec;
    logic [NUM_PINS-1:0] stat_vec;
    logic [NUM_PINS-1:0] req_vec;
    logic [31:0]         word [NUM_PINS];
    logic [31:0]         rd_mux;

    assign sel     = reg_sel_e'(addr[3:2]);
    assign pin_idx = addr[ADDR_W-1:4];

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            pad_cfg_t pc;
            irq_cfg_t ic;
            logic     ov;
            logic     lv;
            logic     st;

            assign hit[p] = (pin_idx == IDX_W'(p));

            gpio_pin_slice #(.SYNC_STAGES(SYNC_STAGES)) u_slice (
                .clk       (clk),
                .rst       (rst),
                .pin_async (pin_in[p]),
                .wr_pad    (wr_en && hit[p] && sel == REG_PAD),
                .wr_io     (wr_en && hit[p] && sel == REG_IO),
                .wr_icfg   (wr_en && hit[p] && sel == REG_ICFG),
                .wr_stat   (wr_en && hit[p] && sel == REG_STAT),
                .wdata     (wdata),
                .pad_cfg   (pc),
                .out_val   (ov),
                .irq_cfg   (ic),
                .status    (st),
                .in_lvl    (lv),
                .irq_req   (req_vec[p])
            );

            assign word[p]          = read_word(sel, pc, ov, lv, ic, st);
            assign pin_out[p]       = ov;
            assign pin_oe[p]        = pc.oe;
            assign pad_pull[2*p +: 2] = pc.pull;
            assign pad_func[4*p +: 4] = pc.func;
            assign pad_drv[3*p +: 3]  = pc.drv;
            assign ien_vec[p]       = ic.irq_en;
            assign cap_vec[p]       = ic.capture_en;
            assign stat_vec[p]      = st;
        end
    endgenerate

    always_comb begin
        rd_mux = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (hit[p]) rd_mux = word[p];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    assign irq = |req_vec;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
    parameter int NUM_PINS = 4,
    parameter int ADDR_W   = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [31:0]         wdata,
    input logic [31:0]         rdata,
    input logic                irq,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_PINS-1:0] ien_vec,
    input logic [NUM_PINS-1:0] cap_vec,
    input logic [NUM_PINS-1:0] stat_vec
);
    localparam int IDX_W = ADDR_W - 4;

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ien_vec != '0)); // R6

    AST_RDATA_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        rdata[31:10] == '0); // R11

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
            AST_STATUS_NEEDS_CAPTURE: assert property (@(posedge clk) disable iff (rst)
                $rose(stat_vec[p]) |-> $past(cap_vec[p])); // R5

            AST_OE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
                (wr_en && addr[ADDR_W-1:4] == IDX_W'(p) && addr[3:2] == 2'd0)
                |=> (pin_oe[p] == $past(wdata[9]))); // R2

            AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
                (wr_en && addr[ADDR_W-1:4] == IDX_W'(p) && addr[3:2] == 2'd3
                 && wdata[0] && !cap_vec[p]) |=> !stat_vec[p]); // R9
        end
    endgenerate
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .irq      (irq),
    .pin_oe   (pin_oe),
    .ien_vec  (ien_vec),
    .cap_vec  (cap_vec),
    .stat_vec (stat_vec)
);

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;
    localparam int NP = 4;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic [2*NP-1:0] pad_pull;
    logic [4*NP-1:0] pad_func;
    logic [3*NP-1:0] pad_drv;
    logic          irq;

    always #2.5 clk = ~clk;

    gpio_irq_bank #(.NUM_PINS(NP), .ADDR_W(AW)) i_gpio_irq_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .pad_pull(pad_pull), .pad_func(pad_func),
        .pad_drv(pad_drv), .irq(irq)
    );

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    logic  rd_fire = 1'b0;

    // monitor: compares each read result with the queued expectation
    always @(posedge clk) rd_fire <= rd_en;
    always @(negedge clk) begin
        if (rd_fire) begin
            n_chk++;
            if (sb_q.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard: unexpected read, actual %h expected none", rdata);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                if (rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, rdata, it.exp);
                end
            end
        end
    end

    function automatic logic [AW-1:0] ra(int pin, int off);
        return AW'(pin * 16 + off);
    endfunction

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(logic [AW-1:0] a, logic [31:0] e, string tag);
        item_t it;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk(logic [31:0] act, logic [31:0] e, string tag);
        n_chk++;
        if (act !== e) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, e);
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        chk(32'(irq), 0, "R12 irq after reset");
        chk(32'(pin_oe), 0, "R12 pin_oe after reset");
        chk(32'(pin_out), 0, "R12 pin_out after reset");
        rd(ra(0, 0), 32'h0, "R12 pad cfg after reset");
        rd(ra(0, 12), 32'h0, "R12 status after reset");

        // R2 pad fields, R11 unused bits
        wr(ra(1, 0), 32'hFFFF_FFFF);
        rd(ra(1, 0), 32'h3FF, "R2 R11 pad readback");
        chk(32'(pin_oe[1]), 1, "R2 oe on port");
        chk(32'(pad_pull[3:2]), 3, "R2 pull on port");
        wr(ra(2, 0), 32'h0000_00D6);
        rd(ra(2, 0), 32'hD6, "R2 pad readback pin2");
        chk(32'(pad_func[11:8]), 5, "R2 func on port");
        chk(32'(pad_drv[8:6]), 3, "R2 drv on port");
        chk(32'(pad_pull[5:4]), 2, "R2 pull pin2");
        chk(32'(pin_oe[2]), 0, "R2 oe pin2 off");

        // R3 input/output register, R1 decode of pin 1
        wr(ra(1, 4), 32'h2);
        chk(32'(pin_out[1]), 1, "R3 pin_out driven");
        rd(ra(1, 4), 32'h2, "R3 io with low input");
        pin_in[1] = 1'b1;
        settle();
        rd(ra(1, 5), 32'h3, "R3 R1 io with high input");

        // R4 interrupt configuration, R11 unmapped
        wr(ra(0, 8), 32'hFF);
        rd(ra(0, 8), 32'hF, "R4 icfg readback");
        rd(ra(4, 0), 32'h0, "R11 unmapped pin 4");
        rd(8'h80, 32'h0, "R11 unmapped high");

        // edge rising, interrupt on, capture off
        wr(ra(0, 8), 32'h7);
        pin_in[0] = 1'b1;
        settle();
        chk(32'(irq), 1, "R6 irq with capture off");
        rd(ra(0, 12), 32'h0, "R5 status held without capture");
        wr(ra(0, 12), 32'h1);
        chk(32'(irq), 0, "R7 pending cleared by W1C");

        // edge rising with capture
        wr(ra(0, 8), 32'hF);
        pin_in[0] = 1'b0;
        settle();
        chk(32'(irq), 0, "R7 falling edge ignored");
        pin_in[0] = 1'b1;
        settle();
        chk(32'(irq), 1, "R7 rising edge");
        rd(ra(0, 12), 32'h1, "R5 status captured");
        pin_in[0] = 1'b0;
        settle();
        chk(32'(irq), 1, "R7 edge pending held");
        wr(ra(0, 12), 32'h0);
        rd(ra(0, 12), 32'h1, "R9 write 0 no effect");
        wr(ra(0, 12), 32'h1);
        rd(ra(0, 12), 32'h0, "R9 W1C clears");
        chk(32'(irq), 0, "R9 irq gone after clear");

        // capture on, interrupt off
        wr(ra(0, 8), 32'hE);
        pin_in[0] = 1'b1;
        settle();
        chk(32'(irq), 0, "R6 no irq when disabled");
        rd(ra(0, 12), 32'h1, "R5 status with irq off");
        wr(ra(0, 12), 32'h1);

        // level high with capture
        wr(ra(0, 8), 32'hB);
        chk(32'(irq), 1, "R8 level active");
        settle();
        wr(ra(0, 12), 32'h1);
        rd(ra(0, 12), 32'h1, "R10 event beats clear");
        pin_in[0] = 1'b0;
        settle();
        chk(32'(irq), 0, "R8 level released");
        wr(ra(0, 12), 32'h1);
        rd(ra(0, 12), 32'h0, "R9 clear after level gone");

        // level low
        wr(ra(0, 8), 32'h1);
        chk(32'(irq), 1, "R8 low level active");
        pin_in[0] = 1'b1;
        settle();
        chk(32'(irq), 0, "R8 low level released");

        // edge falling
        wr(ra(0, 8), 32'h5);
        pin_in[0] = 1'b0;
        settle();
        chk(32'(irq), 1, "R7 falling edge detected");
        pin_in[0] = 1'b1;
        settle();
        chk(32'(irq), 1, "R7 falling pending held");
        wr(ra(0, 12), 32'h1);
        chk(32'(irq), 0, "R7 falling pending cleared");
        wr(ra(0, 8), 32'h0);

        // second pin through the OR
        wr(ra(2, 8), 32'hB);
        pin_in[2] = 1'b1;
        settle();
        chk(32'(irq), 1, "R6 pin2 contributes");
        rd(ra(2, 12), 32'h1, "R1 pin2 status address");
        wr(ra(2, 8), 32'hA);
        chk(32'(irq), 0, "R6 no enabled pin");

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL scoreboard: actual %0d left expected 0", sb_q.size());
        end
        finish_run();
    end
endmodule